// File: doc/BRIEF.md
# Sequenced Shift and Normalize Unit

This unit performs 32-bit logical shifts and normalization on an operand. The operand is reached through byte-wide registers on a simple 8-bit peripheral bus. Software writes the four operand bytes starting with the lowest one. It then writes a control byte that holds an operation code and a shift count, which starts the operation. The unit moves the value one bit per clock while it shows a busy bit. Software then reads the four result bytes, again starting with the lowest one. A normalize keeps shifting left until the top bit is set, and the number of steps it took is written back into the count field.

Two flags are kept by hardware only. The overflow flag is updated by each operation the unit starts. It is also updated by an external completion strobe that reports the overflow outcome of a multiply or divide. The error flag records an access sequence that was cut into or restarted. That covers a second write to the lowest operand byte before the previous sequence was closed, a data read while a shift is running, and a restart that aborts a running shift.

Register map (addresses on `bus_addr`): 0 to 3 are the data bytes, with 0 the least significant. Address 4 is control: bits [4:0] hold the count and bits [6:5] hold the operation, where 00 means none, 01 normalize, 10 shift left and 11 shift right. Address 5 is status and is read-only: bit 0 busy, bit 1 overflow, bit 2 error.

Top module: `shn_unit`

## Requirements
- R1: After reset, the data bytes, the control byte and the status byte all read 0.
- R2: A write to address 0..3 outside a shift stores that byte of the operand, and a read of the same address returns it. Byte 0 holds bits [7:0] and byte 3 holds bits [31:24].
- R3: Writing control with operation 10 and count n shifts the operand left by n bits, filling with zeros. The busy bit (status bit 0) is 1 for exactly n+1 cycles after the clock edge that takes the write.
- R4: Operation 11 with count n shifts the operand right logically by n bits.
- R5: Operation 01 shifts left until bit 31 is 1. The control count field (bits [4:0]) then reads the number of shifts done. An all-zero operand stops after 31 shifts, with a count of 31 and a result of 0.
- R6: A normalize started while bit 31 of the operand is 1 sets the overflow flag (status bit 1). It performs no shift and leaves the count at 0.
- R7: Starting a shift left, a shift right, or a normalize whose operand bit 31 is 0 clears the overflow flag. A pulse on `ext_done` loads the overflow flag with `ext_ovf`.
- R8: Writes to the status address change neither the overflow flag nor the error flag.
- R9: Once byte 0 has been written, writing byte 0 again sets the error flag (status bit 2). This applies until byte 3 is read back outside a shift.
- R10: Reading any data byte while busy is 1 sets the error flag.
- R11: Writing byte 0 while busy aborts the shift. Busy is 0 in the following cycle and the error flag is set.
- R12: Writing byte 0 after a sequence has been closed by a byte 3 read clears the error flag and opens a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| ext_done | input | 1 | Completion strobe from the multiply/divide path |
| ext_ovf | input | 1 | Overflow outcome qualifying `ext_done` |
| busy | output | 1 | High while a shift or normalize runs |

## Verification
The assertions rely on several properties of the inputs. A bus read and a bus write never occur in the same cycle, and the address stays within the six defined registers. A status write never coincides with an `ext_done` pulse, since that pulse legitimately loads the overflow flag. The bench drives every access through one read task and one write task, each of which raises a single strobe for one cycle. It pulses `ext_done` only between bus accesses. Addresses come from fixed constants in the map above.

// File: rtl/shn_pkg.sv
package shn_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_NORM = 2'b01,
      OP_SHL  = 2'b10,
      OP_SHR  = 2'b11
   } shn_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'b00,
      SQ_LOAD   = 2'b01,
      SQ_RUN    = 2'b10,
      SQ_RESULT = 2'b11
   } shn_seq_e;

   localparam int ST_BUSY_BIT = 0;
   localparam int ST_OVF_BIT  = 1;
   localparam int ST_ERR_BIT  = 2;

endpackage

// File: rtl/shn_shift_engine.sv
module shn_shift_engine
   import shn_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W/BYTE_W-1:0] lane_we,
   input  logic [BYTE_W-1:0]     wdata,
   input  logic                  ctrl_we,
   input  shn_op_e               ctrl_op,
   input  logic [CNT_W-1:0]      ctrl_cnt,
   output logic [DATA_W-1:0]     data_q,
   output logic                  busy_q,
   output shn_op_e               op_q,
   output logic [CNT_W-1:0]      cnt_q,
   output logic                  start_o,
   output logic                  start_msb_o,
   output logic                  done_o
);

   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int MSB    = DATA_W - 1;
   localparam logic [CNT_W-1:0] NORM_LIMIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] rem_q;
   logic             abort;
   logic             finish;

   assign start_o     = ctrl_we && !busy_q && (ctrl_op != OP_NONE);
   assign start_msb_o = data_q[MSB];
   assign abort       = lane_we[0] && busy_q;
   assign finish      = busy_q && ((rem_q == '0) || ((op_q == OP_NORM) && data_q[MSB]));
   assign done_o      = finish && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         busy_q <= 1'b0;
         op_q   <= OP_NONE;
         cnt_q  <= '0;
         rem_q  <= '0;
      end else if (abort) begin
         busy_q             <= 1'b0;
         data_q[BYTE_W-1:0] <= wdata;
      end else if (busy_q) begin
         if (finish) begin
            busy_q <= 1'b0;
         end else begin
            rem_q <= rem_q - 1'b1;
            unique case (op_q)
               OP_SHR:  data_q <= {1'b0, data_q[MSB:1]};
               default: data_q <= {data_q[MSB-1:0], 1'b0};
            endcase
            if (op_q == OP_NORM) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin
         for (int i = 0; i < NBYTES; i++) begin
            if (lane_we[i]) begin
               data_q[i*BYTE_W +: BYTE_W] <= wdata;
            end
         end
         if (ctrl_we) begin
            op_q  <= ctrl_op;
            cnt_q <= (ctrl_op == OP_NORM) ? '0 : ctrl_cnt;
            if (start_o) begin
               busy_q <= 1'b1;
               rem_q  <= (ctrl_op == OP_NORM) ? NORM_LIMIT : ctrl_cnt;
            end
         end
      end
   end

endmodule

// File: rtl/shn_access_seq.sv
module shn_access_seq
   import shn_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lane0_we,
   input  logic     data_rd,
   input  logic     top_rd,
   input  logic     start,
   input  logic     busy,
   input  logic     done,
   output shn_seq_e state_q,
   output logic     err_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (lane0_we) begin
         err_q <= (state_q != SQ_IDLE);
      end else if (data_rd && busy) begin
         err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
      end else if (lane0_we) begin
         state_q <= SQ_LOAD;
      end else if (start) begin
         state_q <= SQ_RUN;
      end else begin
         unique case (state_q)
            SQ_RUN:    if (done)   state_q <= SQ_RESULT;
            SQ_LOAD,
            SQ_RESULT: if (top_rd) state_q <= SQ_IDLE;
            default:   state_q <= state_q;
         endcase
      end
   end

endmodule

// File: rtl/shn_ovf_flag.sv
module shn_ovf_flag
   import shn_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  shn_op_e start_op,
   input  logic    start_msb,
   input  logic    ext_done,
   input  logic    ext_ovf,
   output logic    ovf_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (start) begin
         ovf_q <= (start_op == OP_NORM) && start_msb;
      end else if (ext_done) begin
         ovf_q <= ext_ovf;
      end
   end

endmodule

// File: rtl/shn_unit.sv
module shn_unit
   import shn_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_done,
   input  logic              ext_ovf,
   output logic              busy
);

   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int CNT_W  = $clog2(DATA_W);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NBYTES);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NBYTES + 1);
   localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(NBYTES - 1);

   if (DATA_W % BYTE_W != 0) begin : g_chk_lanes
      $error("DATA_W must be a whole number of bytes");
   end
   if ((1 << CNT_W) != DATA_W) begin : g_chk_pow2
      $error("DATA_W must be a power of two");
   end
   if (CNT_W + 2 > BYTE_W) begin : g_chk_ctrl
      $error("count and opcode must fit in one bus byte");
   end
   if ((1 << ADDR_W) < NBYTES + 2) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NBYTES-1:0] lane_we;
   logic              ctrl_we;
   logic              data_rd;
   logic              top_rd;
   shn_op_e           ctrl_op;
   logic [CNT_W-1:0]  ctrl_cnt;

   logic [DATA_W-1:0] eng_data;
   logic              eng_busy;
   shn_op_e           eng_op;
   logic [CNT_W-1:0]  eng_cnt;
   logic              eng_start;
   logic              eng_msb;
   logic              eng_done;
   shn_seq_e          seq_state;
   logic              seq_armed;
   logic              flag_err;
   logic              flag_ovf;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lane_we[g] = bus_wr && (bus_addr == ADDR_W'(g));
   end

   assign ctrl_we  = bus_wr && (bus_addr == CTRL_A);
   assign data_rd  = bus_rd && (bus_addr < CTRL_A);
   assign top_rd   = bus_rd && (bus_addr == TOP_A);
   assign ctrl_op  = shn_op_e'(bus_wdata[CNT_W+1:CNT_W]);
   assign ctrl_cnt = bus_wdata[CNT_W-1:0];

   if (CNT_W + 2 < BYTE_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^bus_wdata[BYTE_W-1:CNT_W+2];
   end

   shn_shift_engine #(
      .DATA_W(DATA_W),
      .BYTE_W(BYTE_W),
      .CNT_W (CNT_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_we    (lane_we),
      .wdata      (bus_wdata),
      .ctrl_we    (ctrl_we),
      .ctrl_op    (ctrl_op),
      .ctrl_cnt   (ctrl_cnt),
      .data_q     (eng_data),
      .busy_q     (eng_busy),
      .op_q       (eng_op),
      .cnt_q      (eng_cnt),
      .start_o    (eng_start),
      .start_msb_o(eng_msb),
      .done_o     (eng_done)
   );

   shn_access_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane0_we(lane_we[0]),
      .data_rd (data_rd),
      .top_rd  (top_rd),
      .start   (eng_start),
      .busy    (eng_busy),
      .done    (eng_done),
      .state_q (seq_state),
      .err_q   (flag_err)
   );

   shn_ovf_flag u_ovf (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .start_op (ctrl_op),
      .start_msb(eng_msb),
      .ext_done (ext_done),
      .ext_ovf  (ext_ovf),
      .ovf_q    (flag_ovf)
   );

   assign seq_armed = (seq_state != SQ_IDLE);
   assign busy      = eng_busy;

   logic [BYTE_W-1:0] byte_arr [NBYTES];
   for (genvar g = 0; g < NBYTES; g++) begin : g_rd
      assign byte_arr[g] = eng_data[g*BYTE_W +: BYTE_W];
   end

   logic [2:0] stat_bits;
   always_comb begin
      stat_bits              = '0;
      stat_bits[ST_BUSY_BIT] = eng_busy;
      stat_bits[ST_OVF_BIT]  = flag_ovf;
      stat_bits[ST_ERR_BIT]  = flag_err;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         for (int i = 0; i < NBYTES; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
               bus_rdata = byte_arr[i];
            end
         end
         if (bus_addr == CTRL_A) begin
            bus_rdata = BYTE_W'({eng_op, eng_cnt});
         end
         if (bus_addr == STAT_A) begin
            bus_rdata = BYTE_W'(stat_bits);
         end
      end
   end

endmodule

// File: rtl/shn_unit_chk.sv
module shn_unit_chk #(
   parameter int ADDR_W = 3,
   parameter int BYTE_W = 8,
   parameter int DATA_W = 32,
   parameter int NBYTES = 4,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              ext_done,
   input logic              busy,
   input logic              ovf,
   input logic              err,
   input logic              armed,
   input logic [DATA_W-1:0] data
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NBYTES);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NBYTES + 1);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !bus_wr) |=> $stable(data));

   a_r6_norm_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_A && bus_wdata[CNT_W+1:CNT_W] == 2'b01 &&
       !busy && data[DATA_W-1]) |=> ovf);

   a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_A && !ext_done) |=> ($stable(ovf) && $stable(err)));

   a_r9_rewrite_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && armed) |=> err);

   a_r10_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr < CTRL_A && busy) |=> err);

   a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && busy) |=> !busy);

   a_r12_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && !armed) |=> (!err && armed));

endmodule

bind shn_unit shn_unit_chk #(
   .ADDR_W(ADDR_W),
   .BYTE_W(BYTE_W),
   .DATA_W(DATA_W),
   .NBYTES(NBYTES),
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .ext_done (ext_done),
   .busy     (eng_busy),
   .ovf      (flag_ovf),
   .err      (flag_err),
   .armed    (seq_armed),
   .data     (eng_data)
);

// File: tb/tb_shn_unit.sv
module tb_shn_unit;

   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_STAT = 3'd5;
   localparam logic [7:0] C_NORM = 8'h20;
   localparam logic [7:0] C_SHL  = 8'h40;
   localparam logic [7:0] C_SHR  = 8'h60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_done = 1'b0;
   logic       ext_ovf = 1'b0;
   logic       busy;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   shn_unit dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ext_done (ext_done),
      .ext_ovf  (ext_ovf),
      .busy     (busy)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic load(logic [31:0] v);
      for (int i = 0; i < 4; i++) wr(3'(i), v[i*8 +: 8]);
   endtask

   task automatic read_all(output logic [31:0] v);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(3'(i), b);
         v[i*8 +: 8] = b;
      end
   endtask

   task automatic wait_idle();
      while (busy) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic t_reset();
      logic [7:0] b;
      rd(A_STAT, b); check("R1 status", 32'(b), 0);
      rd(A_CTRL, b); check("R1 control", 32'(b), 0);
      for (int i = 0; i < 4; i++) begin
         rd(3'(i), b); check("R1 data byte", 32'(b), 0);
      end
   endtask

   task automatic t_load_read();
      logic [31:0] v;
      logic [7:0]  b;
      load(32'h1234_5678);
      read_all(v);
      check("R2 byte order readback", v, 32'h1234_5678);
      rd(A_STAT, b); check("R2 no error on clean sequence", 32'(b), 0);
   endtask

   task automatic t_shift_left();
      logic [31:0] v;
      logic [7:0]  b;
      int n;
      load(32'h0000_0123);
      wr(A_CTRL, C_SHL | 8'd5);
      n = 0;
      while (busy) begin
         @(posedge clk); #1; n++;
      end
      check("R3 busy cycles", 32'(n), 6);
      read_all(v);
      check("R3 shift left by 5", v, 32'h0000_2460);
      rd(A_STAT, b); check("R3 status after", 32'(b), 0);
   endtask

   task automatic t_shift_right();
      logic [31:0] v;
      logic [7:0]  b;
      ext_pulse(1'b1);
      load(32'h8000_0000);
      wr(A_CTRL, C_SHR | 8'd31);
      wait_idle();
      read_all(v);
      check("R4 shift right by 31", v, 32'h0000_0001);
      rd(A_STAT, b); check("R7 shift clears overflow", 32'(b[1]), 0);
   endtask

   task automatic t_normalize();
      logic [31:0] v;
      logic [7:0]  b;
      load(32'h0001_2345);
      wr(A_CTRL, C_NORM);
      wait_idle();
      rd(A_CTRL, b); check("R5 normalize count", 32'(b), 32'h2F);
      read_all(v);
      check("R5 normalize result", v, 32'h91A2_8000);
      load(32'h0);
      wr(A_CTRL, C_NORM);
      wait_idle();
      rd(A_CTRL, b); check("R5 zero operand count", 32'(b), 32'h3F);
      read_all(v);
      check("R5 zero operand result", v, 0);
      rd(A_STAT, b); check("R7 normalize no msb clears ovf", 32'(b), 0);
   endtask

   task automatic t_norm_msb();
      logic [31:0] v;
      logic [7:0]  b;
      load(32'h8000_0001);
      wr(A_CTRL, C_NORM);
      wait_idle();
      rd(A_STAT, b); check("R6 overflow set", 32'(b), 32'h02);
      rd(A_CTRL, b); check("R6 zero shifts", 32'(b), 32'h20);
      read_all(v);
      check("R6 operand unchanged", v, 32'h8000_0001);
   endtask

   task automatic ext_pulse(logic o);
      @(negedge clk);
      ext_done = 1'b1; ext_ovf = o;
      @(posedge clk); #1;
      ext_done = 1'b0; ext_ovf = 1'b0;
   endtask

   task automatic t_ext_and_status();
      logic [7:0] b;
      ext_pulse(1'b1);
      rd(A_STAT, b); check("R7 ext overflow set", 32'(b), 32'h02);
      wr(A_STAT, 8'h00);
      rd(A_STAT, b); check("R8 status write ignored", 32'(b), 32'h02);
      ext_pulse(1'b0);
      rd(A_STAT, b); check("R7 ext overflow cleared", 32'(b), 0);
   endtask

   task automatic t_rewrite();
      logic [7:0] b;
      wr(3'd0, 8'h11);
      wr(3'd1, 8'h22);
      wr(3'd0, 8'h33);
      rd(A_STAT, b); check("R9 rewrite sets error", 32'(b), 32'h04);
      wr(A_STAT, 8'h00);
      rd(A_STAT, b); check("R8 status write keeps error", 32'(b), 32'h04);
      rd(3'd3, b);
      wr(3'd0, 8'h44);
      rd(A_STAT, b); check("R12 fresh start clears error", 32'(b), 0);
      rd(3'd3, b);
   endtask

   task automatic t_read_busy();
      logic [7:0] b;
      load(32'h0000_0001);
      wr(A_CTRL, C_SHL | 8'd20);
      rd(3'd1, b);
      rd(A_STAT, b); check("R10 read while busy", 32'(b), 32'h05);
      wait_idle();
      rd(3'd3, b);
      rd(A_STAT, b); check("R10 error persists", 32'(b), 32'h04);
   endtask

   task automatic t_abort();
      logic [7:0] b;
      wr(3'd0, 8'h01);
      rd(3'd3, b);
      load(32'h0000_0001);
      wr(A_CTRL, C_SHL | 8'd20);
      check("R11 busy before abort", 32'(busy), 1);
      wr(3'd0, 8'hAA);
      check("R11 busy dropped", 32'(busy), 0);
      rd(A_STAT, b); check("R11 error set", 32'(b), 32'h04);
      rd(3'd0, b); check("R11 byte0 takes new value", 32'(b), 32'hAA);
      rd(3'd3, b);
      wr(3'd0, 8'h00);
      rd(A_STAT, b); check("R12 clean after abort", 32'(b), 0);
      rd(3'd3, b);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_load_read();
      t_shift_left();
      t_shift_right();
      t_normalize();
      t_norm_msb();
      t_ext_and_status();
      t_rewrite();
      t_read_busy();
      t_abort();
      summary();
   end

endmodule